// File: doc/BRIEF.md
# Eight-Bit Accumulator ALU with Flag Generation

This block is the arithmetic-logic unit of a small accumulator-style processor core. Each cycle it receives an operation code, the accumulator, a second byte operand and the current flag byte. It returns the new accumulator value and the next flag byte. Each operation writes its own fixed subset of flags. One flag bit carries parity after logical operations and after decimal adjust, and carries signed overflow after arithmetic. Decimal adjust reads the half-carry, subtract and carry flags to bring the accumulator back to packed BCD.

The result path is purely combinational. The flag path ends in a flag register when the parameter `REG_FLAGS` is 1, which is the default. When `REG_FLAGS` is 0, the flags leave the block combinationally as well. There is no state machine. Only the optional flag register holds state.

Top module: `alu8_core`

## Requirements
- R1: Flag byte bits: 7 sign (S), 6 zero (Z), 4 half-carry (H), 2 parity/overflow (PV), 1 subtract (N), 0 carry (C). Op codes: 0 add, 1 add-with-carry, 2 subtract, 3 subtract-with-borrow, 4 compare, 5 negate, 6 AND, 7 OR, 8 XOR, 9 increment, 10 decrement, 11 rotate-left-circular, 12 rotate-right-circular, 13 rotate-left-through-carry, 14 rotate-right-through-carry, 15 decimal adjust, 16 complement, 17 set carry, 18 complement carry. Any other code returns the accumulator unchanged and leaves every flag as it came in.
- R2: Add (op 0) and add-with-carry (op 1, carry-in = C) return (acc+operand+cin) mod 256. They set C to the carry out of bit 7, H to the carry out of bit 3, PV to signed overflow, S to the result MSB and Z when the result is zero, and clear N.
- R3: Subtract (op 2) and subtract-with-borrow (op 3, borrow-in = C) return (acc-operand-bin) mod 256. Negate (op 5) returns (0-acc) mod 256. All three set C on a borrow from bit 8, H on a borrow from bit 4, PV on signed overflow, S and Z from the result, and N to 1.
- R4: Compare (op 4) sets flags exactly as subtract would and returns the accumulator unchanged.
- R5: Increment (op 9) and decrement (op 10) add or subtract one. They update S, Z, H and PV as in R2 and R3, set N to 0 for increment and 1 for decrement, and keep C.
- R6: AND, OR and XOR set S and Z from the result and set PV to 1 when the result has an even number of ones. AND sets H to 1. OR and XOR clear H. All three clear N and C.
- R7: The circular rotates move the bit shifted out into both C and the vacated bit. The through-carry rotates move the old C into the vacated bit and the shifted-out bit into C. All four clear H and N and keep S, Z and PV.
- R8: Decimal adjust (op 15) builds a correction: 0x06 when the low nibble exceeds 9 or H is set, plus 0x60 when the accumulator exceeds 0x99 or C is set. It adds the correction when N is 0 and subtracts it when N is 1. It sets C when the 0x60 part applies and clears C otherwise. H takes the carry or borrow at bit 4 of that correction step. S, Z and PV (parity) come from the result, and N is kept.
- R9: Complement (op 16) returns ~acc, sets H and N, and keeps the other flags. Set carry (op 17) sets C and clears H and N. Complement carry (op 18) inverts C, clears N and keeps H. Both carry operations keep S, Z and PV.
- R10: Flag bits 5 and 3 always pass from flags_in to flags_out unchanged.
- R11: With REG_FLAGS = 1, flags_out reads 0 during reset. It shows the flags for the inputs present at a rising clock edge from that edge onward. The result never waits for a clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the optional flag register |
| rst_n | input | 1 | Asynchronous active-low reset of the flag register |
| op | input | 5 | Operation code (see R1) |
| acc | input | 8 | Accumulator operand |
| operand | input | 8 | Second operand |
| flags_in | input | 8 | Current flag byte |
| result | output | 8 | New accumulator value |
| flags_out | output | 8 | Next flag byte |

## Verification
The result is due in the same cycle as its inputs. The flags are due at the first rising edge after the inputs are applied. The bench applies each operand set on a falling edge. Both outputs are read one time unit after the next rising edge, when the result still reflects the held inputs and the flag register has just captured their flags. One extra test reads flags_out before that edge, to confirm that the old flags are still present there.

// File: rtl/alu8_pkg.sv
package alu8_pkg;

    localparam int DATA_W = 8;
    localparam int NIB_W  = DATA_W / 2;
    localparam int OP_W   = 5;

    localparam int FB_S  = 7;
    localparam int FB_Z  = 6;
    localparam int FB_H  = 4;
    localparam int FB_PV = 2;
    localparam int FB_N  = 1;
    localparam int FB_C  = 0;

    localparam logic [DATA_W-1:0] BCD_MAX = 8'h99;
    localparam logic [DATA_W-1:0] FIX_LO  = 8'h06;
    localparam logic [DATA_W-1:0] FIX_HI  = 8'h60;
    localparam logic [NIB_W-1:0]  NIB_MAX = 4'd9;

    typedef logic [DATA_W-1:0] byte_t;

    typedef enum logic [OP_W-1:0] {
        OP_ADD  = 5'd0,
        OP_ADC  = 5'd1,
        OP_SUB  = 5'd2,
        OP_SBC  = 5'd3,
        OP_CMP  = 5'd4,
        OP_NEG  = 5'd5,
        OP_AND  = 5'd6,
        OP_OR   = 5'd7,
        OP_XOR  = 5'd8,
        OP_INC  = 5'd9,
        OP_DEC  = 5'd10,
        OP_RLC  = 5'd11,
        OP_RRC  = 5'd12,
        OP_RL   = 5'd13,
        OP_RR   = 5'd14,
        OP_DAA  = 5'd15,
        OP_CPL  = 5'd16,
        OP_SCF  = 5'd17,
        OP_CCF  = 5'd18
    } alu_op_e;

    // 1 when the byte holds an even number of ones
    function automatic logic even_par(input byte_t v);
        return ~^v;
    endfunction

endpackage

// File: rtl/alu8_addsub.sv
module alu8_addsub
    import alu8_pkg::*;
(
    input  byte_t x,
    input  byte_t y,
    input  logic  cin,
    input  logic  sub,
    output byte_t sum,
    output logic  c_out,
    output logic  h_out,
    output logic  v_out
);

    byte_t             y_eff;
    logic              c_eff;
    logic [DATA_W:0]   full;
    logic [NIB_W:0]    low;

    // Subtraction runs as x + ~y + ~borrow; the carries are inverted back to borrows.
    always_comb begin
        y_eff = sub ? ~y : y;
        c_eff = sub ? ~cin : cin;
        full  = {1'b0, x} + {1'b0, y_eff} + {{DATA_W{1'b0}}, c_eff};
        low   = {1'b0, x[NIB_W-1:0]} + {1'b0, y_eff[NIB_W-1:0]} + {{NIB_W{1'b0}}, c_eff};
        sum   = full[DATA_W-1:0];
        c_out = full[DATA_W] ^ sub;
        h_out = low[NIB_W] ^ sub;
        v_out = (x[DATA_W-1] == y_eff[DATA_W-1]) && (sum[DATA_W-1] != x[DATA_W-1]);
    end

endmodule

// File: rtl/alu8_bitops.sv
module alu8_bitops
    import alu8_pkg::*;
(
    input  logic [OP_W-1:0] op,
    input  byte_t           a,
    input  byte_t           b,
    input  logic            c_in,
    output byte_t           logic_res,
    output byte_t           rot_res,
    output logic            rot_c
);

    always_comb begin
        unique case (op)
            OP_AND:  logic_res = a & b;
            OP_OR:   logic_res = a | b;
            default: logic_res = a ^ b;
        endcase
    end

    always_comb begin
        unique case (op)
            OP_RLC: begin
                rot_res = {a[DATA_W-2:0], a[DATA_W-1]};
                rot_c   = a[DATA_W-1];
            end
            OP_RRC: begin
                rot_res = {a[0], a[DATA_W-1:1]};
                rot_c   = a[0];
            end
            OP_RL: begin
                rot_res = {a[DATA_W-2:0], c_in};
                rot_c   = a[DATA_W-1];
            end
            default: begin
                rot_res = {c_in, a[DATA_W-1:1]};
                rot_c   = a[0];
            end
        endcase
    end

endmodule

// File: rtl/alu8_bcd.sv
module alu8_bcd
    import alu8_pkg::*;
(
    input  byte_t a,
    input  logic  h_in,
    input  logic  n_in,
    input  logic  c_in,
    output byte_t res,
    output logic  h_out,
    output logic  c_out
);

    logic  fix_lo;
    logic  fix_hi;
    byte_t corr;
    logic  unused_c;
    logic  unused_v;

    always_comb begin
        fix_lo = (a[NIB_W-1:0] > NIB_MAX) || h_in;
        fix_hi = (a > BCD_MAX) || c_in;
        corr   = (fix_lo ? FIX_LO : '0) | (fix_hi ? FIX_HI : '0);
        c_out  = fix_hi;
    end

    // The half-carry is that of the correction step itself.
    alu8_addsub u_fix (
        .x     (a),
        .y     (corr),
        .cin   (1'b0),
        .sub   (n_in),
        .sum   (res),
        .c_out (unused_c),
        .h_out (h_out),
        .v_out (unused_v)
    );

endmodule

// File: rtl/alu8_core.sv
module alu8_core
    import alu8_pkg::*;
#(
    parameter bit REG_FLAGS = 1'b1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [OP_W-1:0]  op,
    input  logic [DATA_W-1:0] acc,
    input  logic [DATA_W-1:0] operand,
    input  logic [DATA_W-1:0] flags_in,
    output logic [DATA_W-1:0] result,
    output logic [DATA_W-1:0] flags_out
);

    byte_t ax, ay, sum;
    logic  acin, asub, ac, ah, av;
    byte_t logic_res, rot_res, bcd_res;
    logic  rot_c, bcd_h, bcd_c;
    byte_t nf;

    // Operand steering for the shared adder
    always_comb begin
        ax   = acc;
        ay   = operand;
        acin = 1'b0;
        asub = 1'b0;
        unique case (op)
            OP_ADC:         acin = flags_in[FB_C];
            OP_SUB, OP_CMP: asub = 1'b1;
            OP_SBC: begin
                asub = 1'b1;
                acin = flags_in[FB_C];
            end
            OP_NEG: begin
                ax   = '0;
                ay   = acc;
                asub = 1'b1;
            end
            OP_INC:         ay = byte_t'(1);
            OP_DEC: begin
                ay   = byte_t'(1);
                asub = 1'b1;
            end
            default: ;
        endcase
    end

    alu8_addsub u_addsub (
        .x     (ax),
        .y     (ay),
        .cin   (acin),
        .sub   (asub),
        .sum   (sum),
        .c_out (ac),
        .h_out (ah),
        .v_out (av)
    );

    alu8_bitops u_bitops (
        .op        (op),
        .a         (acc),
        .b         (operand),
        .c_in      (flags_in[FB_C]),
        .logic_res (logic_res),
        .rot_res   (rot_res),
        .rot_c     (rot_c)
    );

    alu8_bcd u_bcd (
        .a     (acc),
        .h_in  (flags_in[FB_H]),
        .n_in  (flags_in[FB_N]),
        .c_in  (flags_in[FB_C]),
        .res   (bcd_res),
        .h_out (bcd_h),
        .c_out (bcd_c)
    );

    // Result and next-flag selection
    always_comb begin
        result = acc;
        nf     = flags_in;
        unique case (op)
            OP_ADD, OP_ADC, OP_SUB, OP_SBC, OP_NEG, OP_CMP, OP_INC, OP_DEC: begin
                if (op != OP_CMP) result = sum;
                nf[FB_S]  = sum[DATA_W-1];
                nf[FB_Z]  = (sum == '0);
                nf[FB_H]  = ah;
                nf[FB_PV] = av;
                nf[FB_N]  = asub;
                if (op != OP_INC && op != OP_DEC) nf[FB_C] = ac;
            end
            OP_AND, OP_OR, OP_XOR: begin
                result    = logic_res;
                nf[FB_S]  = logic_res[DATA_W-1];
                nf[FB_Z]  = (logic_res == '0);
                nf[FB_H]  = (op == OP_AND);
                nf[FB_PV] = even_par(logic_res);
                nf[FB_N]  = 1'b0;
                nf[FB_C]  = 1'b0;
            end
            OP_RLC, OP_RRC, OP_RL, OP_RR: begin
                result   = rot_res;
                nf[FB_H] = 1'b0;
                nf[FB_N] = 1'b0;
                nf[FB_C] = rot_c;
            end
            OP_DAA: begin
                result    = bcd_res;
                nf[FB_S]  = bcd_res[DATA_W-1];
                nf[FB_Z]  = (bcd_res == '0);
                nf[FB_H]  = bcd_h;
                nf[FB_PV] = even_par(bcd_res);
                nf[FB_C]  = bcd_c;
            end
            OP_CPL: begin
                result   = ~acc;
                nf[FB_H] = 1'b1;
                nf[FB_N] = 1'b1;
            end
            OP_SCF: begin
                nf[FB_C] = 1'b1;
                nf[FB_H] = 1'b0;
                nf[FB_N] = 1'b0;
            end
            OP_CCF: begin
                nf[FB_C] = ~flags_in[FB_C];
                nf[FB_N] = 1'b0;
            end
            default: ;
        endcase
    end

    generate
        if (REG_FLAGS) begin : g_flag_reg
            byte_t flag_q;
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) flag_q <= '0;
                else        flag_q <= nf;
            end
            assign flags_out = flag_q;
        end else begin : g_flag_comb
            assign flags_out = nf;
        end
    endgenerate

endmodule

// File: rtl/alu8_chk.sv
module alu8_chk
    import alu8_pkg::*;
#(
    parameter bit REG_FLAGS = 1'b1
) (
    input logic              clk,
    input logic              rst_n,
    input logic [OP_W-1:0]   op,
    input logic [DATA_W-1:0] acc,
    input logic [DATA_W-1:0] operand,
    input logic [DATA_W-1:0] flags_in,
    input logic [DATA_W-1:0] result,
    input logic [DATA_W-1:0] flags_out
);

    logic [OP_W-1:0] op_d;
    byte_t           fin_d;
    logic            valid;

    // Align the inputs with the cycle in which their flags appear
    generate
        if (REG_FLAGS) begin : g_delay
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    op_d  <= '0;
                    fin_d <= '0;
                    valid <= 1'b0;
                end else begin
                    op_d  <= op;
                    fin_d <= flags_in;
                    valid <= 1'b1;
                end
            end
        end else begin : g_nodelay
            assign op_d  = op;
            assign fin_d = flags_in;
            assign valid = 1'b1;
        end
    endgenerate

    AST_SPARE_BITS_PASS: assert property (@(posedge clk) disable iff (!rst_n)
        valid |-> (flags_out[5] == fin_d[5]) && (flags_out[3] == fin_d[3])); // R10

    AST_INCDEC_KEEP_CARRY: assert property (@(posedge clk) disable iff (!rst_n)
        valid && (op_d == OP_INC || op_d == OP_DEC) |-> flags_out[FB_C] == fin_d[FB_C]); // R5

    AST_LOGIC_CLEAR_NC: assert property (@(posedge clk) disable iff (!rst_n)
        valid && (op_d == OP_AND || op_d == OP_OR || op_d == OP_XOR)
        |-> flags_out[FB_N] == 1'b0 && flags_out[FB_C] == 1'b0); // R6

    AST_ROTATE_KEEP_SZP: assert property (@(posedge clk) disable iff (!rst_n)
        valid && (op_d == OP_RLC || op_d == OP_RRC || op_d == OP_RL || op_d == OP_RR)
        |-> flags_out[FB_S] == fin_d[FB_S] && flags_out[FB_Z] == fin_d[FB_Z]
            && flags_out[FB_PV] == fin_d[FB_PV]); // R7

    AST_SUBTRACT_SETS_N: assert property (@(posedge clk) disable iff (!rst_n)
        valid && (op_d == OP_SUB || op_d == OP_SBC || op_d == OP_NEG)
        |-> flags_out[FB_N] == 1'b1); // R3

    AST_COMPARE_KEEPS_ACC: assert property (@(posedge clk) disable iff (!rst_n)
        op == OP_CMP |-> result == acc); // R4

    AST_UNKNOWN_OP_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        op > OP_CCF |-> result == acc); // R1

endmodule

bind alu8_core alu8_chk #(.REG_FLAGS(REG_FLAGS)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .op        (op),
    .acc       (acc),
    .operand   (operand),
    .flags_in  (flags_in),
    .result    (result),
    .flags_out (flags_out)
);

// File: tb/alu8_core_tb.sv
module alu8_core_tb;

    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 190000;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [4:0] op = '0;
    logic [7:0] acc = '0;
    logic [7:0] operand = '0;
    logic [7:0] flags_in = '0;
    logic [7:0] result;
    logic [7:0] flags_out;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    alu8_core u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .op        (op),
        .acc       (acc),
        .operand   (operand),
        .flags_in  (flags_in),
        .result    (result),
        .flags_out (flags_out)
    );

    function automatic string req_of(input int o);
        if (o <= 1)  return "R2";
        if (o == 4)  return "R4";
        if (o <= 5)  return "R3";
        if (o <= 8)  return "R6";
        if (o <= 10) return "R5";
        if (o <= 14) return "R7";
        if (o == 15) return "R8";
        if (o <= 18) return "R9";
        return "R1";
    endfunction

    function automatic int setb(input int v, input int pos, input int b);
        return b ? (v | (1 << pos)) : (v & ~(1 << pos));
    endfunction

    function automatic int szp(input int f, input int r, input bit with_p);
        int g = setb(f, 7, (r >> 7) & 1);
        g = setb(g, 6, r == 0);
        if (with_p) g = setb(g, 2, ($countones(r[7:0]) % 2) == 0);
        return g;
    endfunction

    // Returns {result, flags}
    function automatic int arith(input int x, input int y, input int cin, input bit sub,
                                 input int f, input bit keep_c);
        int r, t, g, h, v, c;
        if (sub) begin
            t = x - y - cin;
            h = ((x & 15) - (y & 15) - cin) < 0;
            c = t < 0;
            r = t & 255;
            v = (((x ^ y) & (x ^ r)) & 128) != 0;
        end else begin
            t = x + y + cin;
            h = ((x & 15) + (y & 15) + cin) > 15;
            c = t > 255;
            r = t & 255;
            v = ((~(x ^ y) & (x ^ r)) & 128) != 0;
        end
        g = szp(f, r, 1'b0);
        g = setb(g, 4, h);
        g = setb(g, 2, v);
        g = setb(g, 1, sub);
        if (!keep_c) g = setb(g, 0, c);
        return (r << 8) | g;
    endfunction

    function automatic int model(input int o, input int a, input int b, input int f);
        int c = f & 1;
        int h = (f >> 4) & 1;
        int n = (f >> 1) & 1;
        int r = a;
        int g = f;
        int t, lo, hi, corr;
        case (o)
            0:  return arith(a, b, 0, 1'b0, f, 1'b0);
            1:  return arith(a, b, c, 1'b0, f, 1'b0);
            2:  return arith(a, b, 0, 1'b1, f, 1'b0);
            3:  return arith(a, b, c, 1'b1, f, 1'b0);
            4:  return (a << 8) | (arith(a, b, 0, 1'b1, f, 1'b0) & 255);
            5:  return arith(0, a, 0, 1'b1, f, 1'b0);
            6, 7, 8: begin
                r = (o == 6) ? (a & b) : (o == 7) ? (a | b) : (a ^ b);
                g = szp(f, r, 1'b1);
                g = setb(g, 4, o == 6);
                g = setb(g, 1, 0);
                g = setb(g, 0, 0);
            end
            9:  return arith(a, 1, 0, 1'b0, f, 1'b1);
            10: return arith(a, 1, 0, 1'b1, f, 1'b1);
            11, 12, 13, 14: begin
                if (o == 11 || o == 13) begin
                    t = (a >> 7) & 1;
                    r = ((a << 1) & 255) | ((o == 11) ? t : c);
                end else begin
                    t = a & 1;
                    r = (a >> 1) | (((o == 12) ? t : c) << 7);
                end
                g = setb(f, 4, 0);
                g = setb(g, 1, 0);
                g = setb(g, 0, t);
            end
            15: begin
                lo   = ((a & 15) > 9) || h;
                hi   = (a > 153) || c;
                corr = (lo ? 6 : 0) + (hi ? 96 : 0);
                if (n) begin
                    r = (a - corr) & 255;
                    t = (a & 15) < (corr & 15);
                end else begin
                    r = (a + corr) & 255;
                    t = ((a & 15) + (corr & 15)) > 15;
                end
                g = szp(f, r, 1'b1);
                g = setb(g, 4, t);
                g = setb(g, 0, hi);
            end
            16: begin
                r = (~a) & 255;
                g = setb(f, 4, 1);
                g = setb(g, 1, 1);
            end
            17: begin
                g = setb(f, 0, 1);
                g = setb(g, 4, 0);
                g = setb(g, 1, 0);
            end
            18: begin
                g = setb(f, 0, c ^ 1);
                g = setb(g, 1, 0);
            end
            default: ;
        endcase
        return (r << 8) | g;
    endfunction

    task automatic check(input string tag, input string what, input int got, input int exp);
        checks++;
        if (got != exp) begin
            fails++;
            $display("FAIL %s %s: actual %02h expected %02h", tag, what, got, exp);
        end
    endtask

    // Apply on a falling edge; both outputs are read just after the next rising edge.
    task automatic run(input int o, input int a, input int b, input int f);
        int m;
        @(negedge clk);
        op       = 5'(o);
        acc      = 8'(a);
        operand  = 8'(b);
        flags_in = 8'(f);
        m = model(o, a, b, f);
        @(posedge clk);
        #1;
        check(req_of(o), "result", int'(result), (m >> 8) & 255);
        check(req_of(o), "flags", int'(flags_out), m & 255);
        check("R10", "spare bits", int'(flags_out) & 8'h28, f & 8'h28);
    endtask

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  %0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        int m;
        repeat (3) @(negedge clk);
        check("R11", "flags in reset", int'(flags_out), 0);
        rst_n = 1'b1;

        // Directed corner cases
        run(0, 8'h7F, 8'h01, 8'h00);   // R2 signed overflow and half-carry
        run(0, 8'hFF, 8'h01, 8'h00);   // R2 carry out, zero
        run(1, 8'h0F, 8'h00, 8'h01);   // R2 carry-in feeds half-carry
        run(2, 8'h80, 8'h01, 8'h00);   // R3 overflow on subtract
        run(3, 8'h00, 8'h00, 8'h01);   // R3 borrow-in underflow
        run(5, 8'h80, 8'h00, 8'h00);   // R3 negate of most negative
        run(5, 8'h00, 8'h00, 8'h00);   // R3 negate of zero
        run(4, 8'h42, 8'h42, 8'h00);   // R4 equal compare
        run(9, 8'hFF, 8'h00, 8'h00);   // R5 carry kept clear on wrap
        run(10, 8'h00, 8'h00, 8'h01);  // R5 carry kept set
        run(6, 8'hF0, 8'h0F, 8'h3B);   // R6 AND to zero
        run(13, 8'h80, 8'h00, 8'h00);  // R7 through-carry left
        run(15, 8'h9A, 8'h00, 8'h00);  // R8 both corrections after add
        run(15, 8'h0F, 8'h00, 8'h12);  // R8 subtract correction
        run(18, 8'h00, 8'h00, 8'h11);  // R9 complement carry keeps H
        run(25, 8'h5A, 8'h33, 8'hFF);  // R1 unlisted code

        // R11: the flags must not move before the rising edge
        run(17, 8'h00, 8'h00, 8'h00);
        @(negedge clk);
        op = 5'd16; acc = 8'h55; flags_in = 8'h00;
        #1;
        m = model(16, 8'h55, 0, 0);
        check("R11", "result ahead of edge", int'(result), (m >> 8) & 255);
        check("R11", "flags held until edge", int'(flags_out), model(17, 0, 0, 0) & 255);
        @(posedge clk);
        #1;
        check("R11", "flags after edge", int'(flags_out), m & 255);

        // Sweep of every defined code
        for (int o = 0; o <= 18; o++)
            for (int a = 0; a < 256; a++)
                for (int k = 0; k < 12; k++)
                    for (int c = 0; c < 2; c++)
                        run(o, a, (k * 23 + a * 5 + 7) & 255,
                            ((a * 29 + k * 53 + o * 11) & 8'hFE) | c);

        // Unlisted codes
        for (int o = 19; o < 32; o++)
            for (int j = 0; j < 48; j++)
                run(o, (j * 37) & 255, (j * 11) & 255, (j * 71 + o) & 255);

        done = 1'b1;
        $display("  %0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule